// File: doc/BRIEF.md
# Interrupt Controller Programming and Command Decoder

This block is the byte-wide, two-address register front end of an eight-line priority interrupt controller. Software writes it through a one-bit address and a data byte. A byte at the control address with bit 4 set starts a programming sequence that takes three or four bytes. Other bytes at the control address are run-time commands. Bytes at the data address carry the remaining sequence bytes, or load the mask once programming is complete. The block holds the programmed vector base, the nesting and automatic end-of-interrupt modes, and the mask. It turns end-of-interrupt and priority commands into single-cycle strobes for the neighbouring priority resolver.

Reads come back one cycle after the read strobe. Depending on the address and the latest select command, a read returns the resolver's pending register, its in-service register or the mask. When a poll has been armed, the next read returns the number of the highest pending line and tells the resolver to retire that line. A poll read returns 7 when no line is pending. Two modes are recognised but not implemented, single-controller operation and global level triggering, and the block raises a flag if a programming start byte requests either of them.

Top module: `pic_prog_decoder`

## Requirements
- R1: After reset the mask, vector base, every mode flag, the unsupported flag, every strobe, `rd_valid_o` and `rd_data_o` are zero, and `init_busy_o` is low.
- R2: A control-address write with bit 4 set clears the mask, vector base, nesting, auto-EOI, rotate-on-auto-EOI, special-mask, read-select and poll state. It pulses `init_clr_o` for one cycle, raises `init_busy_o`, and records bit 0 as "fourth byte wanted".
- R3: The next data-address write sets the vector base to the byte with bits 2..0 cleared. The write after that is ignored. The sequence then expects a fourth byte if one was wanted, and otherwise returns to normal operation (`init_busy_o` low).
- R4: A fourth byte sets nesting mode (`sfnm_o`) from bit 4 and auto-EOI (`aeoi_o`) from bit 1, then ends the sequence.
- R5: In normal operation a data-address write loads the mask. During a programming sequence the mask is left unchanged.
- R6: A control-address write with bit 4 clear and bit 3 set is a select command. Bit 2 arms a poll. When bit 1 is set, bit 0 chooses in-service (1) or pending (0) for control-address reads. When bit 6 is set, bit 5 becomes `spec_mask_o`.
- R7: A control-address write with bits 4 and 3 clear is an operation command coded in bits 7..5, and it latches bits 2..0 into `cmd_line_o`. The codes pulse strobes for one cycle as follows: code 1 pulses `eoi_nonspec_o`, code 5 pulses `eoi_nonspec_o` and `rotate_o`, code 3 pulses `eoi_spec_o`, code 7 pulses `eoi_spec_o` and `rotate_o`, and code 6 pulses `set_prio_o`.
- R8: Codes 0 and 4 copy bit 7 into `rot_aeoi_o`. Code 2 changes no output.
- R9: A read while a poll is armed returns the pending line number and pulses `poll_clr_o` with `poll_line_o` equal to that number. If no line is pending it returns 7 with no pulse. Either way the poll is disarmed, so the next read is a normal one.
- R10: A read outside poll mode returns the mask at the data address, and at the control address it returns the in-service or pending register as selected. The result is registered, and `rd_valid_o` is high in the cycle after the strobe.
- R11: `unsup_o` takes the OR of bits 1 and 3 of the latest programming start byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the control address, 1 selects the data address |
| wdata_i | input | DATA_W | Write byte |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| irr_i | input | N_LINES | Pending register from the resolver |
| isr_i | input | N_LINES | In-service register from the resolver |
| pend_vld_i | input | 1 | Resolver has a line to deliver |
| pend_line_i | input | LINE_W | Number of that line |
| vec_base_o | output | DATA_W | Programmed vector base |
| sfnm_o | output | 1 | Special nesting mode |
| aeoi_o | output | 1 | Automatic end-of-interrupt |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask_o | output | 1 | Special mask mode |
| imr_o | output | N_LINES | Mask register |
| init_busy_o | output | 1 | Programming sequence in progress |
| unsup_o | output | 1 | Unsupported mode requested |
| init_clr_o | output | 1 | Pulse: resolver must clear its state |
| eoi_nonspec_o | output | 1 | Pulse: retire the highest in-service line |
| eoi_spec_o | output | 1 | Pulse: retire line `cmd_line_o` |
| rotate_o | output | 1 | Qualifies an EOI pulse as rotating |
| set_prio_o | output | 1 | Pulse: make `cmd_line_o` the lowest priority |
| cmd_line_o | output | LINE_W | Line field of the latest operation command |
| poll_clr_o | output | 1 | Pulse: clear pending and in-service of `poll_line_o` |
| poll_line_o | output | LINE_W | Line consumed by the latest poll |
| rd_data_o | output | DATA_W | Read data |
| rd_valid_o | output | 1 | Read data valid |

## Verification
The bench builds the block with its default parameters, eight lines and byte-wide data, so the line field is three bits wide and the idle poll value is 7. With these values all eight operation codes and every line number can be tried exhaustively. Sequences both with and without the fourth byte are reached, and the bench also covers poll reads that find a pending line and poll reads that find none. A behavioural model built on integers follows every clock and is compared against all outputs.

// File: rtl/pic_dec_pkg.sv
package pic_dec_pkg;
  typedef enum logic [1:0] {SEQ_RUN = 2'd0, SEQ_W2 = 2'd1, SEQ_W3 = 2'd2, SEQ_W4 = 2'd3} seq_e;

  typedef struct packed {
    logic eoi_any;
    logic eoi_one;
    logic rotate;
    logic set_prio;
  } cmd_stb_t;

  // control-address bit roles
  localparam int B_START  = 4;
  localparam int B_WANT4  = 0;
  localparam int B_SOLO   = 1;
  localparam int B_LEVEL  = 3;
  localparam int B_NEST   = 4;
  localparam int B_AUTO   = 1;
  localparam int B_SELCMD = 3;
  localparam int B_POLL   = 2;
  localparam int B_RDEN   = 1;
  localparam int B_RDSEL  = 0;
  localparam int B_SMEN   = 6;
  localparam int B_SMVAL  = 5;
  localparam int B_ROTAE  = 7;
  localparam int CMD_LSB  = 5;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3,
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_wr_i,
  input  logic               dat_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               init_hit_o,
  output seq_e               seq_o,
  output logic [DATA_W-1:0]  vec_base_o,
  output logic               sfnm_o,
  output logic               aeoi_o,
  output logic               unsup_o,
  output logic               init_clr_o,
  output logic [N_LINES-1:0] imr_o
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << LINE_W) - 1);

  function automatic logic [DATA_W-1:0] f_vec_base(input logic [DATA_W-1:0] d);
    return d & ~LOW_MASK;
  endfunction

  function automatic logic f_unsup(input logic [DATA_W-1:0] d);
    return d[B_SOLO] | d[B_LEVEL];
  endfunction

  seq_e seq_q;
  logic need4_q;

  assign init_hit_o = ctl_wr_i && wdata_i[B_START];
  assign seq_o      = seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q      <= SEQ_RUN;
      need4_q    <= 1'b0;
      vec_base_o <= '0;
      sfnm_o     <= 1'b0;
      aeoi_o     <= 1'b0;
      unsup_o    <= 1'b0;
      init_clr_o <= 1'b0;
      imr_o      <= '0;
    end else begin
      init_clr_o <= init_hit_o;
      if (init_hit_o) begin
        seq_q      <= SEQ_W2;
        need4_q    <= wdata_i[B_WANT4];
        unsup_o    <= f_unsup(wdata_i);
        vec_base_o <= '0;
        sfnm_o     <= 1'b0;
        aeoi_o     <= 1'b0;
        imr_o      <= '0;
      end else if (dat_wr_i) begin
        case (seq_q)
          SEQ_RUN: imr_o <= wdata_i[N_LINES-1:0];
          SEQ_W2: begin
            vec_base_o <= f_vec_base(wdata_i);
            seq_q      <= SEQ_W3;
          end
          SEQ_W3: seq_q <= need4_q ? SEQ_W4 : SEQ_RUN;
          SEQ_W4: begin
            sfnm_o <= wdata_i[B_NEST];
            aeoi_o <= wdata_i[B_AUTO];
            seq_q  <= SEQ_RUN;
          end
          default: seq_q <= SEQ_RUN;
        endcase
      end
    end
  end

  p_init_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_hit_o |=> (seq_q == SEQ_W2) && (imr_o == '0) && init_clr_o);

  p_w4_needs_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_q == SEQ_W4) |-> need4_q);

  p_mask_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_q != SEQ_RUN) && !init_hit_o |=> $stable(imr_o));

  p_unsup_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_hit_o |=> $stable(unsup_o));
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_dec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic              init_hit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              poll_set_o,
  output logic              rr_sel_o,
  output logic              spec_mask_o,
  output logic              rot_aeoi_o,
  output cmd_stb_t          stb_o,
  output logic [LINE_W-1:0] cmd_line_o
);
  function automatic cmd_stb_t f_cmd(input logic [2:0] code);
    cmd_stb_t s;
    s = '0;
    case (code)
      3'd1: s.eoi_any = 1'b1;
      3'd5: begin s.eoi_any = 1'b1; s.rotate = 1'b1; end
      3'd3: s.eoi_one = 1'b1;
      3'd7: begin s.eoi_one = 1'b1; s.rotate = 1'b1; end
      3'd6: s.set_prio = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

  logic       sel_cmd;
  logic       op_cmd;
  logic [2:0] code;

  assign sel_cmd    = ctl_wr_i && !wdata_i[B_START] && wdata_i[B_SELCMD];
  assign op_cmd     = ctl_wr_i && !wdata_i[B_START] && !wdata_i[B_SELCMD];
  assign code       = wdata_i[CMD_LSB +: 3];
  assign poll_set_o = sel_cmd && wdata_i[B_POLL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_sel_o    <= 1'b0;
      spec_mask_o <= 1'b0;
      rot_aeoi_o  <= 1'b0;
      stb_o       <= '0;
      cmd_line_o  <= '0;
    end else begin
      stb_o <= op_cmd ? f_cmd(code) : '0;
      if (init_hit_i) begin
        rr_sel_o    <= 1'b0;
        spec_mask_o <= 1'b0;
        rot_aeoi_o  <= 1'b0;
      end else if (sel_cmd) begin
        if (wdata_i[B_RDEN]) rr_sel_o <= wdata_i[B_RDSEL];
        if (wdata_i[B_SMEN]) spec_mask_o <= wdata_i[B_SMVAL];
      end else if (op_cmd) begin
        cmd_line_o <= wdata_i[LINE_W-1:0];
        if (code[1:0] == 2'b00) rot_aeoi_o <= wdata_i[B_ROTAE];
      end
    end
  end

  p_stb_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stb_o.eoi_any, stb_o.eoi_one, stb_o.set_prio}));

  p_rotate_qual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o.rotate |-> (stb_o.eoi_any || stb_o.eoi_one));

  p_stb_from_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_i |=> (stb_o == '0));
endmodule

// File: rtl/pic_rd_port.sv
module pic_rd_port #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3,
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic               addr_i,
  input  logic               rr_sel_i,
  input  logic [N_LINES-1:0] imr_i,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic               pend_vld_i,
  input  logic [LINE_W-1:0]  pend_line_i,
  input  logic               poll_set_i,
  input  logic               poll_kill_i,
  output logic               poll_armed_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o,
  output logic               poll_clr_o,
  output logic [LINE_W-1:0]  poll_line_o
);
  localparam logic [DATA_W-1:0] IDLE_POLL = DATA_W'((1 << LINE_W) - 1);

  function automatic logic [DATA_W-1:0] f_poll_byte(input logic vld, input logic [LINE_W-1:0] ln);
    return vld ? DATA_W'(ln) : IDLE_POLL;
  endfunction

  function automatic logic [DATA_W-1:0] f_reg_byte(input logic a, input logic sel,
      input logic [N_LINES-1:0] m, input logic [N_LINES-1:0] p, input logic [N_LINES-1:0] s);
    if (a) return DATA_W'(m);
    return sel ? DATA_W'(s) : DATA_W'(p);
  endfunction

  logic poll_q;
  assign poll_armed_o = poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q      <= 1'b0;
      rd_data_o   <= '0;
      rd_valid_o  <= 1'b0;
      poll_clr_o  <= 1'b0;
      poll_line_o <= '0;
    end else begin
      rd_valid_o <= rd_i;
      poll_clr_o <= 1'b0;
      if (poll_kill_i)     poll_q <= 1'b0;
      else if (poll_set_i) poll_q <= 1'b1;
      else if (rd_i)       poll_q <= 1'b0;
      if (rd_i) begin
        if (poll_q) begin
          rd_data_o <= f_poll_byte(pend_vld_i, pend_line_i);
          if (pend_vld_i) begin
            poll_clr_o  <= 1'b1;
            poll_line_o <= pend_line_i;
          end
        end else begin
          rd_data_o <= f_reg_byte(addr_i, rr_sel_i, imr_i, irr_i, isr_i);
        end
      end
    end
  end

  p_rd_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rd_valid_o);

  p_poll_disarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && poll_q && !poll_set_i |=> !poll_q);

  p_poll_clr_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_clr_o |-> rd_valid_o);
endmodule

// File: rtl/pic_prog_decoder.sv
module pic_prog_decoder
  import pic_dec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int N_LINES = 8,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [N_LINES-1:0] irr_i,
  input  logic [N_LINES-1:0] isr_i,
  input  logic               pend_vld_i,
  input  logic [LINE_W-1:0]  pend_line_i,
  output logic [DATA_W-1:0]  vec_base_o,
  output logic               sfnm_o,
  output logic               aeoi_o,
  output logic               rot_aeoi_o,
  output logic               spec_mask_o,
  output logic [N_LINES-1:0] imr_o,
  output logic               init_busy_o,
  output logic               unsup_o,
  output logic               init_clr_o,
  output logic               eoi_nonspec_o,
  output logic               eoi_spec_o,
  output logic               rotate_o,
  output logic               set_prio_o,
  output logic [LINE_W-1:0]  cmd_line_o,
  output logic               poll_clr_o,
  output logic [LINE_W-1:0]  poll_line_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               rd_valid_o
);
  logic     ctl_wr;
  logic     dat_wr;
  logic     init_hit;
  seq_e     seq;
  logic     poll_set;
  logic     rr_sel;
  logic     poll_armed;
  cmd_stb_t stb;

  assign ctl_wr = wr_i && !addr_i;
  assign dat_wr = wr_i && addr_i;

  pic_init_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W), .N_LINES(N_LINES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr), .dat_wr_i(dat_wr),
    .wdata_i(wdata_i), .init_hit_o(init_hit), .seq_o(seq),
    .vec_base_o(vec_base_o), .sfnm_o(sfnm_o), .aeoi_o(aeoi_o),
    .unsup_o(unsup_o), .init_clr_o(init_clr_o), .imr_o(imr_o)
  );

  pic_cmd_dec #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_wr_i(ctl_wr), .init_hit_i(init_hit),
    .wdata_i(wdata_i), .poll_set_o(poll_set), .rr_sel_o(rr_sel),
    .spec_mask_o(spec_mask_o), .rot_aeoi_o(rot_aeoi_o), .stb_o(stb),
    .cmd_line_o(cmd_line_o)
  );

  pic_rd_port #(.DATA_W(DATA_W), .LINE_W(LINE_W), .N_LINES(N_LINES)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .addr_i(addr_i),
    .rr_sel_i(rr_sel), .imr_i(imr_o), .irr_i(irr_i), .isr_i(isr_i),
    .pend_vld_i(pend_vld_i), .pend_line_i(pend_line_i),
    .poll_set_i(poll_set), .poll_kill_i(init_hit), .poll_armed_o(poll_armed),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .poll_clr_o(poll_clr_o), .poll_line_o(poll_line_o)
  );

  assign init_busy_o   = (seq != SEQ_RUN);
  assign eoi_nonspec_o = stb.eoi_any;
  assign eoi_spec_o    = stb.eoi_one;
  assign rotate_o      = stb.rotate;
  assign set_prio_o    = stb.set_prio;

  p_init_disarms_poll_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_hit |=> !poll_armed && init_busy_o);

  p_ctl_no_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr && !init_hit |=> $stable(imr_o));
endmodule

// File: tb/pic_prog_decoder_tb.sv
module pic_prog_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] irr = 8'h00;
  logic [7:0] isr = 8'h00;
  logic       pvld = 1'b0;
  logic [2:0] pline = 3'd0;

  logic [7:0] vec_base, imr, rd_data;
  logic       sfnm, aeoi, rot_aeoi, smm, busy, unsup, init_clr;
  logic       eoi_ns, eoi_sp, rot, setp, poll_clr, rd_valid;
  logic [2:0] cmd_line, poll_line;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pic_prog_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .irr_i(irr), .isr_i(isr), .pend_vld_i(pvld), .pend_line_i(pline),
    .vec_base_o(vec_base), .sfnm_o(sfnm), .aeoi_o(aeoi), .rot_aeoi_o(rot_aeoi),
    .spec_mask_o(smm), .imr_o(imr), .init_busy_o(busy), .unsup_o(unsup),
    .init_clr_o(init_clr), .eoi_nonspec_o(eoi_ns), .eoi_spec_o(eoi_sp),
    .rotate_o(rot), .set_prio_o(setp), .cmd_line_o(cmd_line),
    .poll_clr_o(poll_clr), .poll_line_o(poll_line), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid)
  );

  // behavioural reference: phase 0 run, 2..4 waiting for byte 2..4
  int m_phase, m_want4, m_vec, m_sfnm, m_aeoi, m_rae, m_smm, m_imr, m_unsup;
  int m_iclr, m_ens, m_esp, m_rot, m_setp, m_line, m_pclr, m_pline;
  int m_rdata, m_rvld, m_poll, m_rsel;

  task automatic m_reset();
    m_phase = 0; m_want4 = 0; m_vec = 0; m_sfnm = 0; m_aeoi = 0; m_rae = 0;
    m_smm = 0; m_imr = 0; m_unsup = 0; m_iclr = 0; m_ens = 0; m_esp = 0;
    m_rot = 0; m_setp = 0; m_line = 0; m_pclr = 0; m_pline = 0;
    m_rdata = 0; m_rvld = 0; m_poll = 0; m_rsel = 0;
  endtask

  task automatic m_step();
    int w, c;
    w = wdata;
    m_iclr = 0; m_ens = 0; m_esp = 0; m_rot = 0; m_setp = 0; m_pclr = 0; m_rvld = 0;
    if (rd) begin
      m_rvld = 1;
      if (m_poll != 0) begin
        if (pvld) begin m_rdata = pline; m_pclr = 1; m_pline = pline; end
        else m_rdata = 7;
        m_poll = 0;
      end else if (addr) m_rdata = m_imr;
      else m_rdata = (m_rsel != 0) ? isr : irr;
    end
    if (wr && !addr) begin
      if (w & 16) begin
        m_phase = 2; m_want4 = w & 1; m_unsup = ((w >> 1) & 1) | ((w >> 3) & 1);
        m_vec = 0; m_sfnm = 0; m_aeoi = 0; m_imr = 0; m_rae = 0; m_smm = 0;
        m_rsel = 0; m_poll = 0; m_iclr = 1;
      end else if (w & 8) begin
        if (w & 4) m_poll = 1;
        if (w & 2) m_rsel = w & 1;
        if (w & 64) m_smm = (w >> 5) & 1;
      end else begin
        c = w >> 5;
        m_line = w % 8;
        if (c == 0 || c == 4) m_rae = c / 4;
        if (c == 1 || c == 5) m_ens = 1;
        if (c == 3 || c == 7) m_esp = 1;
        if (c == 5 || c == 7) m_rot = 1;
        if (c == 6) m_setp = 1;
      end
    end else if (wr && addr) begin
      if (m_phase == 0) m_imr = w;
      else if (m_phase == 2) begin m_vec = (w / 8) * 8; m_phase = 3; end
      else if (m_phase == 3) m_phase = (m_want4 != 0) ? 4 : 0;
      else begin m_sfnm = (w >> 4) & 1; m_aeoi = (w >> 1) & 1; m_phase = 0; end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R1-model vec_base", vec_base, m_vec);
    chk("R4-model sfnm", sfnm, m_sfnm);
    chk("R4-model aeoi", aeoi, m_aeoi);
    chk("R8-model rot_aeoi", rot_aeoi, m_rae);
    chk("R6-model spec_mask", smm, m_smm);
    chk("R5-model imr", imr, m_imr);
    chk("R3-model busy", busy, m_phase != 0);
    chk("R11-model unsup", unsup, m_unsup);
    chk("R2-model init_clr", init_clr, m_iclr);
    chk("R7-model eoi_ns", eoi_ns, m_ens);
    chk("R7-model eoi_sp", eoi_sp, m_esp);
    chk("R7-model rotate", rot, m_rot);
    chk("R7-model set_prio", setp, m_setp);
    chk("R7-model cmd_line", cmd_line, m_line);
    chk("R9-model poll_clr", poll_clr, m_pclr);
    chk("R9-model poll_line", poll_line, m_pline);
    chk("R10-model rd_data", rd_data, m_rdata);
    chk("R10-model rd_valid", rd_valid, m_rvld);
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else m_step();
    #2;
    if (!done) cmp_model();
  end

  task automatic wr_b(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 imr", imr, 0); chk("R1 vec", vec_base, 0); chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 unsup", unsup, 0); chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    // sequence with fourth byte
    wr_b(1'b1, 8'h5A);
    chk("R5 mask load", imr, 8'h5A);
    wr_b(1'b0, 8'h11);
    chk("R2 init_clr pulse", init_clr, 1); chk("R2 busy", busy, 1);
    chk("R2 imr cleared", imr, 0); chk("R11 unsup clear", unsup, 0);
    wr_b(1'b1, 8'h2D);
    chk("R3 vec base", vec_base, 8'h28); chk("R5 mask untouched in init", imr, 0);
    wr_b(1'b1, 8'hFF);
    chk("R3 third byte ignored", vec_base, 8'h28); chk("R3 awaits fourth", busy, 1);
    wr_b(1'b1, 8'h12);
    chk("R4 sfnm", sfnm, 1); chk("R4 aeoi", aeoi, 1); chk("R4 done", busy, 0);
    wr_b(1'b1, 8'hA5);
    chk("R5 mask", imr, 8'hA5);
    rd_b(1'b1);
    chk("R10 mask read", rd_data, 8'hA5); chk("R10 valid", rd_valid, 1);
    // sequence without fourth byte, unsupported modes
    wr_b(1'b0, 8'h1A);
    chk("R11 unsup set", unsup, 1); chk("R2 sfnm cleared", sfnm, 0); chk("R2 imr", imr, 0);
    wr_b(1'b1, 8'hFF);
    chk("R3 vec low bits", vec_base, 8'hF8);
    wr_b(1'b1, 8'h00);
    chk("R3 no fourth", busy, 0);
    wr_b(1'b1, 8'h3C);
    chk("R5 mask after short seq", imr, 8'h3C);
    wr_b(1'b0, 8'h12);
    chk("R11 second start", unsup, 1);
    wr_b(1'b0, 8'h10);
    chk("R11 cleared by start", unsup, 0);
    wr_b(1'b1, 8'h00); wr_b(1'b1, 8'h00);
    // select commands
    irr = 8'h3C; isr = 8'h81;
    rd_b(1'b0); chk("R10 pending default", rd_data, 8'h3C);
    wr_b(1'b0, 8'h0B); rd_b(1'b0); chk("R6 in-service sel", rd_data, 8'h81);
    wr_b(1'b0, 8'h08); rd_b(1'b0); chk("R6 select kept", rd_data, 8'h81);
    wr_b(1'b0, 8'h0A); rd_b(1'b0); chk("R6 pending sel", rd_data, 8'h3C);
    wr_b(1'b0, 8'h68); chk("R6 smm on", smm, 1);
    wr_b(1'b0, 8'h28); chk("R6 smm kept", smm, 1);
    wr_b(1'b0, 8'h48); chk("R6 smm off", smm, 0);
    // operation commands
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); addr = 1'b0; wdata = 8'((c << 5) | 5); wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      chk("R7 eoi_ns", eoi_ns, (c == 1 || c == 5) ? 1 : 0);
      chk("R7 eoi_sp", eoi_sp, (c == 3 || c == 7) ? 1 : 0);
      chk("R7 rotate", rot, (c == 5 || c == 7) ? 1 : 0);
      chk("R7 set_prio", setp, (c == 6) ? 1 : 0);
      chk("R7 line", cmd_line, 5);
      if (c == 4) chk("R8 rot_aeoi set", rot_aeoi, 1);
      if (c == 0) chk("R8 rot_aeoi clear", rot_aeoi, 0);
      if (c == 2) chk("R8 code 2 inert", rot_aeoi, 0);
    end
    @(negedge clk); chk("R7 pulse one cycle", eoi_sp, 0);
    // poll
    pvld = 1'b1; pline = 3'd6;
    wr_b(1'b0, 8'h0C); rd_b(1'b1);
    chk("R9 poll line", rd_data, 6); chk("R9 poll clr", poll_clr, 1); chk("R9 poll_line", poll_line, 6);
    rd_b(1'b0); chk("R9 disarmed", rd_data, 8'h3C); chk("R9 no clr", poll_clr, 0);
    pvld = 1'b0;
    wr_b(1'b0, 8'h0C); rd_b(1'b0);
    chk("R9 none pending", rd_data, 7); chk("R9 none clr", poll_clr, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule